// File: doc/BRIEF.md
# Host-Link Loss Watchdog

This block stops the radio when the host computer goes quiet, for instance after the host software crashes or the network cable is pulled. It watches two single-cycle pulses: one for every packet the radio sends toward the host, and one for every packet that arrives from the host. In steady operation these two streams keep a fixed integer proportion. That proportion depends on how many receivers are active and on the receive bandwidth, and it is supplied on two small ports. The block measures how far the host has fallen behind, counted in packets rather than in clock cycles. When the host's arrears reach a programmable limit, the block drops the effective run bit and forces transmit off.

The block keeps a credit counter. Every outbound packet adds the host-side weight, and every inbound packet removes the radio-side weight, so traffic at the expected proportion leaves the counter where it started. The counter never goes below zero. The watchdog is only armed while the host commands run. Once it has fired, it stays fired until the host issues a new run command, which it does by lowering and raising its run request. A practical limit is a few hundred packet periods: at 2.625 ms per packet, 256 periods give roughly two thirds of a second. Very small limits trip on ordinary host pauses, such as a transmit-to-receive switch.

Top module: `host_link_guard`

## Requirements
- R1: While reset is asserted, and right after it, `fired_o` and `tx_inhibit_o` are low and the credit is zero; `run_o` equals `host_run_i` whenever the watchdog has not fired.
- R2: While armed, each cycle with `tx_pkt_i` high adds `ratio_recv_i` (m) to the credit, and each cycle with `rx_pkt_i` high subtracts `ratio_sent_i` (n); the credit saturates at zero and never banks surplus host packets.
- R3: The watchdog fires when the updated credit reaches `limit_i` × m. `fired_o` goes high right after the clock edge that samples the outbound pulse reaching that value, so with n = m = 1 and limit L, the L-th unanswered outbound pulse fires it.
- R4: Traffic in the configured proportion (n outbound pulses for every m inbound pulses) never fires the watchdog, however long it lasts.
- R5: An outbound and an inbound pulse in the same cycle are both applied in that cycle (net change m − n).
- R6: While `host_run_i` is low, the watchdog is disarmed, the credit is held at zero and `fired_o` cannot rise; pulses seen while disarmed do not count later.
- R7: Once fired, `fired_o` stays high and `run_o` stays low for as long as `host_run_i` stays high, whatever pulses arrive.
- R8: `tx_inhibit_o` asserts in the same cycle as `fired_o` and remains asserted, even if `host_run_i` falls, until the watchdog is re-armed.
- R9: Only a rising edge of `host_run_i` re-arms a fired watchdog. `fired_o` is low from the next cycle on, and counting restarts from zero credit.
- R10: A `limit_i` of zero or a `ratio_recv_i` of zero disables firing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_pkt_i | input | 1 | One-cycle pulse per packet sent toward the host |
| rx_pkt_i | input | 1 | One-cycle pulse per packet received from the host |
| ratio_sent_i | input | RATIO_W | n: outbound packets per proportion unit |
| ratio_recv_i | input | RATIO_W | m: inbound packets expected per proportion unit |
| host_run_i | input | 1 | Run request from the host |
| limit_i | input | LIMIT_W | Arrears limit in outbound packet slots |
| run_o | output | 1 | Effective run bit |
| tx_inhibit_o | output | 1 | Forces transmit off |
| fired_o | output | 1 | Watchdog has expired |

## Verification
The bench builds the block with its default widths: a 4-bit ratio and a 16-bit limit. The limit is driven at the port with small values (1 to 5), so expiry, re-arm and back-to-back firing happen within tens of cycles. The 4-bit ratio ports reach unequal proportions such as 2:3 and 3:1, where each inbound pulse removes a different amount than each outbound pulse adds. They also reach the zero weight that disables the block. A bench-side credit model, derived from the requirements, predicts the three outputs after every clock edge.

// File: rtl/host_link_guard_pkg.sv
// Package: shared types for the host-link loss watchdog.
// Assumes: nothing beyond standard SystemVerilog packed structs.
package host_link_guard_pkg;

    // One cycle's packet activity on the host link.
    typedef struct packed {
        logic sent;   // packet toward the host this cycle
        logic recv;   // packet from the host this cycle
    } pkt_evt_t;

endpackage

// File: rtl/hlg_rise_detect.sv
// Module: hlg_rise_detect
// Detects a low-to-high transition of a level input.
// Assumes: the input is synchronous to clk. The history register
// resets low, so a level already high out of reset counts as a rise.
module hlg_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);
    logic prev_q;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    // Rise is high now but low last cycle.
    always_comb rise_o = level_i & ~prev_q;
endmodule

// File: rtl/hlg_credit_counter.sv
// Module: hlg_credit_counter
// Keeps the host's arrears as a credit. Outbound packets add the
// inbound weight (m) and inbound packets remove the outbound weight (n).
// The credit saturates at zero. The module raises trip_o when the
// updated credit reaches limit*m (a product of zero never trips).
// Assumes: once tripped, the caller drops en_i, which clears the credit,
// so the credit stays below limit*m + m and fits in CREDIT_W bits.
module hlg_credit_counter
    import host_link_guard_pkg::*;
#(
    parameter int RATIO_W = 4,
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  pkt_evt_t           evt_i,
    input  logic [RATIO_W-1:0] ratio_sent_i,
    input  logic [RATIO_W-1:0] ratio_recv_i,
    input  logic [LIMIT_W-1:0] limit_i,
    output logic               trip_o
);
    localparam int TGT_W    = LIMIT_W + RATIO_W;
    localparam int CREDIT_W = TGT_W + 1;

    logic [CREDIT_W-1:0] credit_q;
    logic [CREDIT_W-1:0] credit_sum;
    logic [CREDIT_W-1:0] credit_next;
    logic [CREDIT_W-1:0] debit;
    logic [TGT_W-1:0]    target;

    // Firing point: limit scaled by the inbound weight.
    always_comb target = TGT_W'(limit_i) * TGT_W'(ratio_recv_i);

    // Apply both pulses of this cycle, clamping at zero.
    always_comb begin
        credit_sum = credit_q + (evt_i.sent ? CREDIT_W'(ratio_recv_i) : '0);
        debit      = evt_i.recv ? CREDIT_W'(ratio_sent_i) : '0;
        credit_next = (credit_sum >= debit) ? (credit_sum - debit) : '0;
    end

    // Trip when armed, enabled by a non-zero target, and reached.
    always_comb trip_o = en_i && (target != '0) &&
                         (credit_next >= CREDIT_W'(target));

    // Credit register: counts while armed, cleared otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     credit_q <= '0;
        else if (en_i)  credit_q <= credit_next;
        else            credit_q <= '0;
    end

    // R2
    // The credit cannot grow in a cycle without an outbound pulse.
    no_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !evt_i.sent) |=> (credit_q <= $past(credit_q)));

    // R6
    // A disarmed cycle leaves no credit behind.
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (credit_q == '0));
endmodule

// File: rtl/hlg_fire_latch.sv
// Module: hlg_fire_latch
// Holds the expiry state. It is set by a trip and cleared only by a
// re-arm strobe. A trip wins if both arrive in the same cycle.
// Assumes: the trip and re-arm strobes are synchronous single-cycle levels.
module hlg_fire_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    input  logic rearm_i,
    output logic fired_o
);
    logic fired_q;

    // Sticky expiry flag.
    always_ff @(posedge clk) begin
        if (!rst_n) fired_q <= 1'b0;
        else        fired_q <= trip_i | (fired_q & ~rearm_i);
    end

    always_comb fired_o = fired_q;

    // R7
    // Without a re-arm, a fired state persists.
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fired_q && !rearm_i) |=> fired_q);
endmodule

// File: rtl/host_link_guard.sv
// Module: host_link_guard (top)
// Host-link loss watchdog. It compares outbound and inbound packet pulses
// against a configured n:m proportion. When the host falls limit_i
// outbound slots behind, it clears the effective run bit and inhibits
// transmit until the host re-issues run with a rising edge.
// Assumes: packet pulses are one cycle wide and synchronous to clk.
module host_link_guard
    import host_link_guard_pkg::*;
#(
    parameter int RATIO_W = 4,
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_pkt_i,
    input  logic               rx_pkt_i,
    input  logic [RATIO_W-1:0] ratio_sent_i,
    input  logic [RATIO_W-1:0] ratio_recv_i,
    input  logic               host_run_i,
    input  logic [LIMIT_W-1:0] limit_i,
    output logic               run_o,
    output logic               tx_inhibit_o,
    output logic               fired_o
);
    pkt_evt_t evt;
    logic     armed;
    logic     run_rise;
    logic     trip;
    logic     fired;

    // Bundle this cycle's packet pulses.
    always_comb begin
        evt.sent = tx_pkt_i;
        evt.recv = rx_pkt_i;
    end

    // Armed while the host asks to run and no expiry is pending.
    always_comb armed = host_run_i & ~fired;

    hlg_rise_detect run_edge_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (host_run_i),
        .rise_o  (run_rise)
    );

    hlg_credit_counter #(
        .RATIO_W (RATIO_W),
        .LIMIT_W (LIMIT_W)
    ) credit_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (armed),
        .evt_i        (evt),
        .ratio_sent_i (ratio_sent_i),
        .ratio_recv_i (ratio_recv_i),
        .limit_i      (limit_i),
        .trip_o       (trip)
    );

    hlg_fire_latch latch_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .trip_i  (trip),
        .rearm_i (run_rise),
        .fired_o (fired)
    );

    // Drive the outputs from the expiry state.
    always_comb begin
        fired_o      = fired;
        tx_inhibit_o = fired;
        run_o        = host_run_i & ~fired;
    end

    // R3
    // Expiry can only follow an outbound packet.
    fire_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fired_o) |-> $past(tx_pkt_i));

    // R6
    // No expiry can begin while the host has run low.
    disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_run_i && !fired_o) |=> !fired_o);

    // R9
    // Leaving the fired state needs the host to have been asking for run.
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fired_o) |-> $past(host_run_i));

    // R10
    // A zero limit or zero inbound weight never expires.
    disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fired_o) |-> ($past(limit_i) != '0 && $past(ratio_recv_i) != '0));

    // R8
    // Inhibit is released only together with the expiry flag.
    inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_inhibit_o) |-> $fell(fired_o));
endmodule

// File: tb/host_link_guard_tb_top.sv
// Directed bench for host_link_guard with a requirement-derived model.
module host_link_guard_tb_top;
    localparam int RW = 4;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_pkt = 1'b0;
    logic          rx_pkt = 1'b0;
    logic          host_run = 1'b0;
    logic [RW-1:0] n_sent = 4'd1;
    logic [RW-1:0] m_recv = 4'd1;
    logic [LW-1:0] limit = 16'd4;
    logic          run_o, inhibit_o, fired_o;

    int tests = 0;
    int fails = 0;
    int mc = 0;
    bit mf = 1'b0;
    bit mprev = 1'b0;

    always #5 clk = ~clk;

    host_link_guard #(.RATIO_W(RW), .LIMIT_W(LW)) dut_i (
        .clk (clk), .rst_n (rst_n), .tx_pkt_i (tx_pkt), .rx_pkt_i (rx_pkt),
        .ratio_sent_i (n_sent), .ratio_recv_i (m_recv), .host_run_i (host_run),
        .limit_i (limit), .run_o (run_o), .tx_inhibit_o (inhibit_o),
        .fired_o (fired_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model, check after the edge.
    task automatic step(input bit run, input bit s, input bit r, input string req);
        int tgt, c2;
        bit armed, rise, set;
        @(negedge clk);
        host_run = run; tx_pkt = s; rx_pkt = r;
        armed = run && !mf;
        rise  = run && !mprev;
        tgt   = int'(limit) * int'(m_recv);
        set   = 1'b0;
        if (armed) begin
            c2 = mc + (s ? int'(m_recv) : 0) - (r ? int'(n_sent) : 0);
            if (c2 < 0) c2 = 0;
            set = (tgt != 0) && (c2 >= tgt);
            mc  = c2;
        end else mc = 0;
        mf    = set || (mf && !rise);
        mprev = run;
        @(posedge clk); #1;
        chk(fired_o == mf, req, "fired_o", fired_o, mf);
        chk(inhibit_o == mf, {req, "/R8"}, "tx_inhibit_o", inhibit_o, mf);
        chk(run_o == (run && !mf), {req, "/R7"}, "run_o", run_o, run && !mf);
        tx_pkt = 0; rx_pkt = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; host_run = 0;
        @(posedge clk); #1;
        chk(fired_o == 0 && inhibit_o == 0, "R1", "reset flags", fired_o, 0);
        chk(run_o == 0, "R1", "run_o with run low", run_o, 0);
        @(negedge clk); host_run = 1; #1;
        chk(run_o == 1, "R1", "run_o follows host in reset", run_o, 1);
        @(posedge clk); @(negedge clk);
        host_run = 0; rst_n = 1;
        mc = 0; mf = 0; mprev = 0;
        @(posedge clk); #1;
        mprev = 0;
    endtask

    // R3: silent host with 1:1 and limit 4 fires on the 4th send.
    task automatic t_silent();
        n_sent = 1; m_recv = 1; limit = 4;
        step(1, 0, 0, "R3");
        for (int i = 0; i < 3; i++) step(1, 1, 0, "R3");
        chk(fired_o == 0, "R3", "before limit", fired_o, 0);
        step(1, 1, 0, "R3");
        chk(fired_o == 1 && inhibit_o == 1, "R3", "at limit", fired_o, 1);
    endtask

    // R7, R8, R9: sticky, inhibit held over run drop, re-arm by rise.
    task automatic t_sticky_rearm();
        for (int i = 0; i < 6; i++) step(1, i % 2 == 0, 1, "R7");
        chk(fired_o == 1 && run_o == 0, "R7", "sticky while run high", fired_o, 1);
        step(0, 0, 0, "R8");
        step(0, 0, 0, "R8");
        chk(inhibit_o == 1, "R8", "inhibit after run drop", inhibit_o, 1);
        step(1, 0, 0, "R9");
        step(1, 0, 0, "R9");
        chk(fired_o == 0 && run_o == 1, "R9", "re-armed", fired_o, 0);
        for (int i = 0; i < 3; i++) step(1, 1, 0, "R9");
        chk(fired_o == 0, "R9", "credit restarted", fired_o, 0);
        step(1, 1, 0, "R9");
        chk(fired_o == 1, "R9", "fires again at limit", fired_o, 1);
        step(0, 0, 0, "R9");
        step(1, 0, 0, "R9");
    endtask

    // R4: balanced traffic at 1:1 and at 2:3 never fires.
    task automatic t_balanced();
        n_sent = 1; m_recv = 1; limit = 2;
        for (int i = 0; i < 40; i++) begin
            step(1, 1, 0, "R4");
            step(1, 0, 1, "R4");
        end
        chk(fired_o == 0, "R4", "1:1 balanced", fired_o, 0);
        n_sent = 2; m_recv = 3; limit = 3;
        for (int i = 0; i < 20; i++) begin
            step(1, 1, 0, "R4"); step(1, 1, 0, "R4");
            step(1, 0, 1, "R4"); step(1, 0, 1, "R4"); step(1, 0, 1, "R4");
        end
        chk(fired_o == 0, "R4", "2:3 balanced", fired_o, 0);
        // R2: with weight 3 per send and target 9, the third lone send fires.
        step(1, 1, 0, "R2"); step(1, 1, 0, "R2");
        chk(fired_o == 0, "R2", "two weighted sends", fired_o, 0);
        step(1, 1, 0, "R2");
        chk(fired_o == 1, "R2", "third weighted send", fired_o, 1);
        step(0, 0, 0, "R2"); step(1, 0, 0, "R2");
    endtask

    // R5: simultaneous pulses at 1:1 leave the credit unchanged.
    task automatic t_simul();
        n_sent = 1; m_recv = 1; limit = 3;
        step(1, 1, 0, "R5"); step(1, 1, 0, "R5");
        for (int i = 0; i < 10; i++) step(1, 1, 1, "R5");
        chk(fired_o == 0, "R5", "net zero", fired_o, 0);
        step(1, 1, 0, "R5");
        chk(fired_o == 1, "R5", "one more send fires", fired_o, 1);
        step(0, 0, 0, "R5"); step(1, 0, 0, "R5");
        // 3:1 with simultaneous pulses: net -2 per cycle, saturates.
        n_sent = 3; m_recv = 1; limit = 2;
        step(1, 1, 0, "R5"); step(1, 1, 1, "R5"); step(1, 1, 0, "R5");
        chk(fired_o == 0, "R5", "simultaneous debit applied", fired_o, 0);
        step(1, 1, 0, "R5");
        chk(fired_o == 1, "R5", "fires after debit", fired_o, 1);
        step(0, 0, 0, "R5"); step(1, 0, 0, "R5");
    endtask

    // R2: excess host packets are not banked below zero.
    task automatic t_saturate();
        n_sent = 1; m_recv = 1; limit = 3;
        for (int i = 0; i < 20; i++) step(1, 0, 1, "R2");
        step(1, 1, 0, "R2"); step(1, 1, 0, "R2");
        chk(fired_o == 0, "R2", "two sends after surplus", fired_o, 0);
        step(1, 1, 0, "R2");
        chk(fired_o == 1, "R2", "no banked surplus", fired_o, 1);
        step(0, 0, 0, "R2"); step(1, 0, 0, "R2");
    endtask

    // R6: sends while run is low do not count.
    task automatic t_disarmed();
        n_sent = 1; m_recv = 1; limit = 3;
        step(0, 0, 0, "R6");
        for (int i = 0; i < 8; i++) step(0, 1, 0, "R6");
        chk(fired_o == 0 && run_o == 0, "R6", "disarmed", fired_o, 0);
        step(1, 1, 0, "R6"); step(1, 1, 0, "R6");
        chk(fired_o == 0, "R6", "count from zero", fired_o, 0);
        step(1, 1, 0, "R6");
        chk(fired_o == 1, "R6", "third armed send", fired_o, 1);
        step(0, 0, 0, "R6"); step(1, 0, 0, "R6");
    endtask

    // R10: zero limit or zero inbound weight disables firing.
    task automatic t_disable();
        n_sent = 1; m_recv = 1; limit = 0;
        for (int i = 0; i < 30; i++) step(1, 1, 0, "R10");
        chk(fired_o == 0, "R10", "zero limit", fired_o, 0);
        m_recv = 0; limit = 5;
        for (int i = 0; i < 30; i++) step(1, 1, 0, "R10");
        chk(fired_o == 0, "R10", "zero inbound weight", fired_o, 0);
        m_recv = 1; limit = 1;
        step(0, 0, 0, "R10"); step(1, 0, 0, "R10");
        step(1, 1, 0, "R10");
        chk(fired_o == 1, "R10", "limit 1 fires on one send", fired_o, 1);
    endtask

    initial begin
        fork
            begin
                do_reset();
                t_silent();
                t_sticky_rearm();
                t_balanced();
                t_simul();
                t_saturate();
                t_disarmed();
                t_disable();
            end
            begin
                repeat (20000) @(posedge clk);
                tests++; fails++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule